// File: doc/BRIEF.md
# Erase-then-Store Content Addressable Memory

This block is a small content addressable memory of 16 slots, each holding one byte. A lookup presents a byte and, one clock later, returns a vector with one bit per slot. A bit is set when that slot holds the presented byte. The vector is also reduced to a match-found flag, the index of the lowest matching slot and an optional flag that marks a single, unambiguous match.

Match state is held as a table indexed by data value. Each row has one bit per slot, so a lookup is a single row read. A write takes two clock cycles while the write enable stays high. In the first cycle the slot's previous byte is removed from the table. That byte is found through a shadow copy of every stored byte. In the second cycle the new byte is recorded. A write enable pulse of only one cycle therefore leaves the slot empty. The whole block clears on an asynchronous global reset.

Top module: `es_cam`

## Requirements
- R1: While and after the global reset, `match_vec`, `hit`, `match_idx` and `single` are all zero, and an immediately following lookup of 0x00 returns an all-zero vector. Empty slots match no byte.
- R2: A lookup is taken at a rising edge where `look_en`=1 and `look_clr`=0. From that edge on, bit i of `match_vec` is 1 exactly when slot i holds `key`.
- R3: Holding `wr_en` high for two cycles with the same `wr_slot` and `key` replaces the slot's old byte. Afterwards the old byte no longer matches that slot and the new byte does.
- R4: A `wr_en` pulse of a single cycle erases the addressed slot and stores nothing. The slot then matches neither its old byte nor the byte on `key`.
- R5: While `look_en`=0, `match_vec` keeps its value whatever `key` is.
- R6: At an edge with `look_en`=1 and `look_clr`=1, `match_vec` becomes all zeros.
- R7: `hit` is 1 exactly when at least one bit of `match_vec` is 1.
- R8: When `hit` is 1, `match_idx` is the lowest slot index whose bit is set in `match_vec`.
- R9: `single` is 1 only when exactly one bit of `match_vec` is set. It is 0 for zero or several matches.
- R10: A lookup taken on the same edge as a store cycle sees the table as it was before that store.
- R11: While `wr_en` stays high, the cycles alternate erase, store, erase and so on. Three cycles of `wr_en` therefore erase, store and then erase again, leaving the slot empty.
- R12: While `look_en`=0, `look_clr` has no effect and `match_vec` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| grst | input | 1 | Asynchronous global reset, active high |
| key | input | 8 | Byte to look up or to write |
| wr_slot | input | 4 | Slot index for writes |
| wr_en | input | 1 | Write enable; two cycles erase then store |
| look_en | input | 1 | Lookup enable; when low the match vector holds |
| look_clr | input | 1 | Synchronous clear of the match vector, effective with look_en |
| match_vec | output | 16 | Registered per-slot match bits |
| hit | output | 1 | At least one slot matched |
| match_idx | output | 4 | Lowest matching slot index |
| single | output | 1 | Exactly one slot matched |

## Verification
A lookup and the store cycle of a write can land on the same clock edge. Both act on the same table row when the key is the byte being written. The bench provokes this by raising the lookup enable only for the second cycle of a two-cycle write to an empty slot, with the same byte on `key`. It judges the result by requiring an all-zero vector from that edge and the new slot's bit from a separate lookup afterwards.

// File: rtl/es_cam_pkg.sv
package es_cam_pkg;
   typedef enum logic {
      PH_ERASE = 1'b0,
      PH_STORE = 1'b1
   } wr_phase_e;
endpackage

// File: rtl/es_cam_phase.sv
module es_cam_phase
   import es_cam_pkg::*;
(
   input  logic clk,
   input  logic grst,
   input  logic wr_en,
   output logic erase_en,
   output logic store_en
);
   wr_phase_e ph;

   always_ff @(posedge clk or posedge grst) begin
      if (grst)
         ph <= PH_ERASE;
      else if (!wr_en)
         ph <= PH_ERASE;
      else
         ph <= (ph == PH_ERASE) ? PH_STORE : PH_ERASE;
   end

   assign erase_en = wr_en && (ph == PH_ERASE);
   assign store_en = wr_en && (ph == PH_STORE);

   // R11: phase alternates while enable is held, and falls back to erase otherwise
   a_r11_alternate: assert property (@(posedge clk) disable iff (grst)
      (wr_en && ph == PH_ERASE) |=> (ph == PH_STORE));
   a_r11_idle_erase: assert property (@(posedge clk) disable iff (grst)
      !wr_en |=> (ph == PH_ERASE));
endmodule

// File: rtl/es_cam_shadow.sv
module es_cam_shadow #(
   parameter int ENTRIES = 16,
   parameter int DATA_W  = 8
) (
   input  logic                       clk,
   input  logic                       grst,
   input  logic                       store_en,
   input  logic [$clog2(ENTRIES)-1:0] slot,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          old_byte
);
   logic [DATA_W-1:0] copy_q [ENTRIES];

   always_ff @(posedge clk or posedge grst) begin
      if (grst) begin
         for (int i = 0; i < ENTRIES; i++) copy_q[i] <= '0;
      end else if (store_en) begin
         copy_q[slot] <= wdata;
      end
   end

   assign old_byte = copy_q[slot];

   // R3: the shadow follows the stored byte
   a_r3_shadow: assert property (@(posedge clk) disable iff (grst)
      store_en |=> (copy_q[$past(slot)] == $past(wdata)));
endmodule

// File: rtl/es_cam_table.sv
module es_cam_table #(
   parameter int ENTRIES = 16,
   parameter int DATA_W  = 8
) (
   input  logic                       clk,
   input  logic                       grst,
   input  logic                       erase_en,
   input  logic                       store_en,
   input  logic [$clog2(ENTRIES)-1:0] slot,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [DATA_W-1:0]          old_byte,
   input  logic                       look_en,
   input  logic                       look_clr,
   output logic [ENTRIES-1:0]         mvec
);
   localparam int ROWS = 1 << DATA_W;

   logic [ENTRIES-1:0] row_q [ROWS];

   always_ff @(posedge clk or posedge grst) begin
      if (grst) begin
         for (int r = 0; r < ROWS; r++) row_q[r] <= '0;
         mvec <= '0;
      end else begin
         if (erase_en) row_q[old_byte][slot] <= 1'b0;
         if (store_en) row_q[wdata][slot]    <= 1'b1;
         if (look_en)  mvec <= look_clr ? '0 : row_q[wdata];
      end
   end

   // R3: a store marks the new byte at the slot
   a_r3_store_set: assert property (@(posedge clk) disable iff (grst)
      store_en |=> row_q[$past(wdata)][$past(slot)]);
   // R4: an erase removes the old byte from the slot
   a_r4_erase_clear: assert property (@(posedge clk) disable iff (grst)
      erase_en |=> !row_q[$past(old_byte)][$past(slot)]);
   // R5 and R12: vector holds while lookups are disabled
   a_r5_hold: assert property (@(posedge clk) disable iff (grst)
      !look_en |=> $stable(mvec));
   // R6: enabled clear zeroes the vector
   a_r6_clear: assert property (@(posedge clk) disable iff (grst)
      (look_en && look_clr) |=> (mvec == '0));
endmodule

// File: rtl/es_cam_encode.sv
module es_cam_encode #(
   parameter int ENTRIES    = 16,
   parameter bit HAS_SINGLE = 1'b1
) (
   input  logic [ENTRIES-1:0]         vec,
   output logic                       any,
   output logic [$clog2(ENTRIES)-1:0] idx,
   output logic                       one
);
   localparam int AW = $clog2(ENTRIES);

   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (vec[i]) idx = AW'(i);
      end
   end

   assign any = |vec;

   generate
      if (HAS_SINGLE) begin : g_single
         assign one = any && ((vec & (vec - 1'b1)) == '0);
      end else begin : g_nosingle
         assign one = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/es_cam.sv
module es_cam #(
   parameter int ENTRIES    = 16,
   parameter int DATA_W     = 8,
   parameter bit HAS_SINGLE = 1'b1
) (
   input  logic                       clk,
   input  logic                       grst,
   input  logic [DATA_W-1:0]          key,
   input  logic [$clog2(ENTRIES)-1:0] wr_slot,
   input  logic                       wr_en,
   input  logic                       look_en,
   input  logic                       look_clr,
   output logic [ENTRIES-1:0]         match_vec,
   output logic                       hit,
   output logic [$clog2(ENTRIES)-1:0] match_idx,
   output logic                       single
);
   localparam int AW = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2 || (1 << AW) != ENTRIES) begin : g_bad_entries
         $error("es_cam: ENTRIES must be a power of two of at least 2");
      end
      if (DATA_W < 1 || DATA_W > 10) begin : g_bad_width
         $error("es_cam: DATA_W must lie between 1 and 10");
      end
   endgenerate

   logic              erase_en;
   logic              store_en;
   logic [DATA_W-1:0] old_byte;

   es_cam_phase u_phase (
      .clk      (clk),
      .grst     (grst),
      .wr_en    (wr_en),
      .erase_en (erase_en),
      .store_en (store_en)
   );

   es_cam_shadow #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_shadow (
      .clk      (clk),
      .grst     (grst),
      .store_en (store_en),
      .slot     (wr_slot),
      .wdata    (key),
      .old_byte (old_byte)
   );

   es_cam_table #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_table (
      .clk      (clk),
      .grst     (grst),
      .erase_en (erase_en),
      .store_en (store_en),
      .slot     (wr_slot),
      .wdata    (key),
      .old_byte (old_byte),
      .look_en  (look_en),
      .look_clr (look_clr),
      .mvec     (match_vec)
   );

   es_cam_encode #(.ENTRIES(ENTRIES), .HAS_SINGLE(HAS_SINGLE)) u_enc (
      .vec (match_vec),
      .any (hit),
      .idx (match_idx),
      .one (single)
   );

   // R8: the reported index points at a set bit
   a_r8_idx_set: assert property (@(posedge clk) disable iff (grst)
      hit |-> match_vec[match_idx]);
   // R9: a single match means exactly the indexed bit is set
   a_r9_single: assert property (@(posedge clk) disable iff (grst)
      single |-> ($countones(match_vec) == 1));
   // R7: a match flag only with a non-empty vector
   a_r7_hit: assert property (@(posedge clk) disable iff (grst)
      (match_vec == '0) |-> !hit);
endmodule

// File: tb/sim_es_cam.sv
module sim_es_cam;
   logic        clk = 1'b0;
   logic        grst = 1'b1;
   logic [7:0]  key = '0;
   logic [3:0]  wr_slot = '0;
   logic        wr_en = 1'b0;
   logic        look_en = 1'b0;
   logic        look_clr = 1'b0;
   logic [15:0] match_vec;
   logic        hit;
   logic [3:0]  match_idx;
   logic        single;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int model [16];

   es_cam u0 (
      .clk(clk), .grst(grst), .key(key), .wr_slot(wr_slot), .wr_en(wr_en),
      .look_en(look_en), .look_clr(look_clr), .match_vec(match_vec),
      .hit(hit), .match_idx(match_idx), .single(single)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_vec(input logic [7:0] d);
      logic [15:0] v = '0;
      for (int i = 0; i < 16; i++) if (model[i] == int'(d)) v[i] = 1'b1;
      return v;
   endfunction

   task automatic check_outputs(input string req, input logic [15:0] v);
      int lo = 0;
      int n = 0;
      for (int i = 15; i >= 0; i--) if (v[i]) begin lo = i; n++; end
      chk({req, " vec"}, match_vec, v);
      chk("R7 hit", hit, (v != 0));
      if (v != 0) chk("R8 idx", match_idx, lo);
      chk("R9 single", single, (n == 1));
   endtask

   task automatic lookup(input string req, input logic [7:0] d);
      @(negedge clk);
      look_en = 1'b1; look_clr = 1'b0; key = d;
      @(negedge clk);
      look_en = 1'b0;
      check_outputs(req, exp_vec(d));
   endtask

   task automatic write_cycles(input int s, input logic [7:0] d, input int n);
      @(negedge clk);
      wr_en = 1'b1; wr_slot = 4'(s); key = d;
      for (int c = 1; c < n; c++) @(negedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      model[s] = (n == 2) ? int'(d) : -1;
   endtask

   task automatic t_reset;
      chk("R1 vec", match_vec, 0);
      chk("R1 hit", hit, 0);
      chk("R1 idx", match_idx, 0);
      chk("R1 single", single, 0);
      lookup("R1", 8'h00);
   endtask

   task automatic t_basic;
      write_cycles(3, 8'h5A, 2);
      write_cycles(9, 8'h5A, 2);
      write_cycles(12, 8'hC3, 2);
      lookup("R2 two", 8'h5A);
      lookup("R2 one", 8'hC3);
      lookup("R2 none", 8'h11);
   endtask

   task automatic t_overwrite;
      write_cycles(3, 8'h77, 2);
      lookup("R3 old", 8'h5A);
      lookup("R3 new", 8'h77);
   endtask

   task automatic t_pulse;
      write_cycles(9, 8'h99, 1);
      lookup("R4 old", 8'h5A);
      lookup("R4 new", 8'h99);
   endtask

   task automatic t_three;
      write_cycles(12, 8'h44, 3);
      lookup("R11 new", 8'h44);
      lookup("R11 old", 8'hC3);
   endtask

   task automatic t_hold_clear;
      lookup("R5 setup", 8'h77);
      @(negedge clk);
      key = 8'h00; look_clr = 1'b1; look_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 R12 hold", match_vec, 16'h0008);
      look_en = 1'b1;
      @(negedge clk);
      look_en = 1'b0; look_clr = 1'b0;
      chk("R6 clear", match_vec, 0);
   endtask

   task automatic t_same_edge;
      @(negedge clk);
      wr_en = 1'b1; wr_slot = 4'd5; key = 8'h66;
      @(negedge clk);
      look_en = 1'b1; look_clr = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; look_en = 1'b0;
      chk("R10 pre-store view", match_vec, 0);
      model[5] = 'h66;
      lookup("R10 after", 8'h66);
      write_cycles(0, 8'h66, 2);
      lookup("R8 lowest", 8'h66);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) model[i] = -1;
      repeat (3) @(negedge clk);
      t_reset_in_reset();
      grst = 1'b0;
      @(negedge clk);
      t_reset;
      t_basic;
      t_overwrite;
      t_pulse;
      t_three;
      t_hold_clear;
      t_same_edge;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic t_reset_in_reset;
      chk("R1 in reset", {match_vec, hit, single}, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule